// File: doc/BRIEF.md
# Spatial Control Dispatcher for a Processing-Element Grid

This block sits between an array sequencer and a rectangular grid of processing elements. Each time it is handed a new set of operation words, it works out a role for every cell of the grid and gives each cell a registered opcode and enable. The role depends on the selected control pattern, the cell's row and column, and a per-cell mask. A single command can therefore steer several regions of the grid at once. The diagonal can run one operation while the rest runs another. Chosen rows or columns can run a secondary stream. A triangular part can be active with the cells beneath it idle. A triangular part can also sit beside a square part that follows the secondary stream.

Three operation words arrive with each command: main, diagonal and secondary. All cells that share a role receive the same word. A cell that is masked, or that lies outside the active shape, receives opcode zero (no operation) with its enable low. The outputs load on the clock edge where the valid strobe is high and keep their values otherwise.

Top module: `sad_dispatch`

## Requirements
- R1: While reset is applied, and after it is released until the first accepted command, every cell shows enable 0 and opcode 0.
- R2: The outputs change one clock after the edge where `valid_i` is high, and hold their values on every edge where `valid_i` is low, whatever the other inputs do.
- R3: Mode 3'b000 (broadcast): every unmasked cell gets enable 1 and the main operation word.
- R4: Cell (r,c) is controlled by mask bit r*COLS+c. When that bit is 1, the cell gets enable 0 and opcode 0 in every mode. Opcode 0 means no operation.
- R5: Mode 3'b001 (diagonal split): cells with r==c get the diagonal word, and all other cells get the main word.
- R6: Mode 3'b010 (row split): cells in a row whose `row_sel_i` bit r is 1 get the secondary word, and all other cells get the main word.
- R7: Mode 3'b011 (column split): cells in a column whose `col_sel_i` bit c is 1 get the secondary word, and all other cells get the main word.
- R8: Mode 3'b100 (triangular): cells with c==r get the diagonal word, cells with c>r get the main word, and cells with c<r are inactive (enable 0, opcode 0).
- R9: Mode 3'b101 (triangle beside square): columns c < COLS/2 follow the R8 rules, and columns c >= COLS/2 get the secondary word in every row.
- R10: Codes 3'b110 and 3'b111 are reserved and behave exactly as broadcast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| valid_i | input | 1 | Command strobe; loads a new grid setting |
| mode_i | input | 3 | Control pattern code |
| main_op_i | input | OPW | Main-stream operation word |
| diag_op_i | input | OPW | Diagonal-stream operation word |
| sec_op_i | input | OPW | Secondary-stream operation word |
| mask_i | input | ROWS*COLS | Per-cell disable mask; bit r*COLS+c belongs to cell (r,c) |
| row_sel_i | input | ROWS | Row selection for row split |
| col_sel_i | input | COLS | Column selection for column split |
| cell_op_o | output | ROWS*COLS*OPW | Registered opcodes; cell (r,c) occupies slice (r*COLS+c)*OPW +: OPW |
| cell_en_o | output | ROWS*COLS | Registered enables, one per cell |

## Verification
The bench builds the block with its defaults: a 4x4 grid, 8-bit opcodes, and a triangle width of two columns. With a two-column triangle, the triangle-beside-square mode puts cells on both sides of the boundary. It also leaves rows 2 and 3 of the triangular columns entirely inactive. Since the grid is square, diagonal, triangular and split rules meet in the same cells. Mask patterns are chosen to overlap the diagonal and the selected rows and columns, which shows that the mask overrides every role.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [2:0] {
    MODE_BCAST = 3'b000,
    MODE_DIAG  = 3'b001,
    MODE_ROW   = 3'b010,
    MODE_COL   = 3'b011,
    MODE_TRI   = 3'b100,
    MODE_TRISQ = 3'b101
  } sad_mode_e;

  typedef enum logic [1:0] {
    ROLE_IDLE = 2'd0,
    ROLE_MAIN = 2'd1,
    ROLE_DIAG = 2'd2,
    ROLE_SEC  = 2'd3
  } sad_role_e;

endpackage

// File: rtl/sad_mode_dec.sv
module sad_mode_dec
  import sad_pkg::*;
(
  input  logic [2:0] mode_raw,
  output sad_mode_e  mode
);

  // reserved codes fold onto broadcast
  always_comb begin
    case (mode_raw)
      3'b001:  mode = MODE_DIAG;
      3'b010:  mode = MODE_ROW;
      3'b011:  mode = MODE_COL;
      3'b100:  mode = MODE_TRI;
      3'b101:  mode = MODE_TRISQ;
      default: mode = MODE_BCAST;
    endcase
  end

endmodule

// File: rtl/sad_role_map.sv
module sad_role_map
  import sad_pkg::*;
#(
  parameter int ROW_IDX = 0,
  parameter int COL_IDX = 0,
  parameter int TRI_W   = 2
) (
  input  sad_mode_e mode,
  input  logic      row_hit,
  input  logic      col_hit,
  output sad_role_e role
);

  localparam bit ON_DIAG  = (ROW_IDX == COL_IDX);
  localparam bit ABOVE    = (COL_IDX > ROW_IDX);
  localparam bit IN_TRI_W = (COL_IDX < TRI_W);

  sad_role_e tri_role;

  // role inside a triangular region (diagonal at top-left)
  always_comb begin
    if (ON_DIAG)    tri_role = ROLE_DIAG;
    else if (ABOVE) tri_role = ROLE_MAIN;
    else            tri_role = ROLE_IDLE;
  end

  always_comb begin
    case (mode)
      MODE_DIAG:  role = ON_DIAG ? ROLE_DIAG : ROLE_MAIN;
      MODE_ROW:   role = row_hit ? ROLE_SEC : ROLE_MAIN;
      MODE_COL:   role = col_hit ? ROLE_SEC : ROLE_MAIN;
      MODE_TRI:   role = tri_role;
      MODE_TRISQ: role = IN_TRI_W ? tri_role : ROLE_SEC;
      default:    role = ROLE_MAIN;
    endcase
  end

endmodule

// File: rtl/sad_cell_reg.sv
module sad_cell_reg
  import sad_pkg::*;
#(
  parameter int OPW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  sad_role_e      role,
  input  logic           masked,
  input  logic [OPW-1:0] main_op,
  input  logic [OPW-1:0] diag_op,
  input  logic [OPW-1:0] sec_op,
  output logic [OPW-1:0] op_q,
  output logic           en_q
);

  logic [OPW-1:0] op_d;
  logic           en_d;

  // next-state: idle or masked cells get NOP with enable low
  always_comb begin
    op_d = '0;
    en_d = 1'b0;
    if (!masked) begin
      case (role)
        ROLE_MAIN: begin op_d = main_op; en_d = 1'b1; end
        ROLE_DIAG: begin op_d = diag_op; en_d = 1'b1; end
        ROLE_SEC:  begin op_d = sec_op;  en_d = 1'b1; end
        default:   begin op_d = '0;      en_d = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= '0;
      en_q <= 1'b0;
    end else if (load) begin
      op_q <= op_d;
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/sad_dispatch.sv
module sad_dispatch
  import sad_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int OPW  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid_i,
  input  logic [2:0]               mode_i,
  input  logic [OPW-1:0]           main_op_i,
  input  logic [OPW-1:0]           diag_op_i,
  input  logic [OPW-1:0]           sec_op_i,
  input  logic [ROWS*COLS-1:0]     mask_i,
  input  logic [ROWS-1:0]          row_sel_i,
  input  logic [COLS-1:0]          col_sel_i,
  output logic [ROWS*COLS*OPW-1:0] cell_op_o,
  output logic [ROWS*COLS-1:0]     cell_en_o
);

  localparam int CELLS = ROWS * COLS;
  localparam int TRI_W = COLS / 2;

  // asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  sad_mode_e mode;

  sad_mode_dec u_dec (
    .mode_raw (mode_i),
    .mode     (mode)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      sad_role_e role;

      sad_role_map #(
        .ROW_IDX (r),
        .COL_IDX (c),
        .TRI_W   (TRI_W)
      ) u_map (
        .mode    (mode),
        .row_hit (row_sel_i[r]),
        .col_hit (col_sel_i[c]),
        .role    (role)
      );

      sad_cell_reg #(
        .OPW (OPW)
      ) u_cell (
        .clk     (clk),
        .rst_n   (rst_sync_n),
        .load    (valid_i),
        .role    (role),
        .masked  (mask_i[IDX]),
        .main_op (main_op_i),
        .diag_op (diag_op_i),
        .sec_op  (sec_op_i),
        .op_q    (cell_op_o[IDX*OPW +: OPW]),
        .en_q    (cell_en_o[IDX])
      );
    end
  end

endmodule

// File: rtl/sad_chk.sv
module sad_chk #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int OPW  = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     valid_i,
  input logic [2:0]               mode_i,
  input logic [OPW-1:0]           main_op_i,
  input logic [OPW-1:0]           diag_op_i,
  input logic [ROWS*COLS-1:0]     mask_i,
  input logic [ROWS*COLS*OPW-1:0] cell_op_o,
  input logic [ROWS*COLS-1:0]     cell_en_o
);

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(cell_en_o) && $stable(cell_op_o)));

  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      localparam int IDX = r * COLS + c;

      // R4
      nop_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cell_en_o[IDX] |-> (cell_op_o[IDX*OPW +: OPW] == '0));

      // R4
      mask_kills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mask_i[IDX]) |=> !cell_en_o[IDX]);

      // R3
      bcast_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode_i == 3'b000 && !mask_i[IDX]) |=>
          (cell_en_o[IDX] && cell_op_o[IDX*OPW +: OPW] == $past(main_op_i)));

      if (c < r) begin : g_below
        // R8
        tri_below_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (valid_i && mode_i == 3'b100) |=> !cell_en_o[IDX]);
      end

      if (c == r) begin : g_diag
        // R5
        diag_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (valid_i && mode_i == 3'b001 && !mask_i[IDX]) |=>
            (cell_en_o[IDX] && cell_op_o[IDX*OPW +: OPW] == $past(diag_op_i)));
      end
    end
  end

endmodule

bind sad_dispatch sad_chk #(
  .ROWS (ROWS),
  .COLS (COLS),
  .OPW  (OPW)
) u_sad_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_i   (valid_i),
  .mode_i    (mode_i),
  .main_op_i (main_op_i),
  .diag_op_i (diag_op_i),
  .mask_i    (mask_i),
  .cell_op_o (cell_op_o),
  .cell_en_o (cell_en_o)
);

// File: tb/tb_sad_dispatch.sv
module tb_sad_dispatch;

  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int OPW   = 8;
  localparam int CELLS = ROWS * COLS;
  localparam int TRI_W = COLS / 2;

  logic                 clk;
  logic                 rst_n;
  logic                 valid_i;
  logic [2:0]           mode_i;
  logic [OPW-1:0]       main_op_i, diag_op_i, sec_op_i;
  logic [CELLS-1:0]     mask_i;
  logic [ROWS-1:0]      row_sel_i;
  logic [COLS-1:0]      col_sel_i;
  logic [CELLS*OPW-1:0] cell_op_o;
  logic [CELLS-1:0]     cell_en_o;

  int n_chk;
  int n_bad;
  logic [OPW-1:0] exp_op [CELLS];
  logic           exp_en [CELLS];

  sad_dispatch #(.ROWS(ROWS), .COLS(COLS), .OPW(OPW)) dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .mode_i(mode_i),
    .main_op_i(main_op_i), .diag_op_i(diag_op_i), .sec_op_i(sec_op_i),
    .mask_i(mask_i), .row_sel_i(row_sel_i), .col_sel_i(col_sel_i),
    .cell_op_o(cell_op_o), .cell_en_o(cell_en_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected grid from the requirements: 0 idle, 1 main, 2 diagonal, 3 secondary
  task automatic compute_expected();
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        int role;
        int idx;
        idx = r * COLS + c;
        case (mode_i)
          3'b001:  role = (r == c) ? 2 : 1;
          3'b010:  role = row_sel_i[r] ? 3 : 1;
          3'b011:  role = col_sel_i[c] ? 3 : 1;
          3'b100:  role = (c == r) ? 2 : ((c > r) ? 1 : 0);
          3'b101:  role = (c >= TRI_W) ? 3 : ((c == r) ? 2 : ((c > r) ? 1 : 0));
          default: role = 1;
        endcase
        if (mask_i[idx]) role = 0;
        exp_en[idx] = (role != 0);
        case (role)
          1:       exp_op[idx] = main_op_i;
          2:       exp_op[idx] = diag_op_i;
          3:       exp_op[idx] = sec_op_i;
          default: exp_op[idx] = '0;
        endcase
      end
    end
  endtask

  task automatic check_grid(input string req);
    for (int i = 0; i < CELLS; i++) begin
      n_chk++;
      if (cell_en_o[i] !== exp_en[i] || cell_op_o[i*OPW +: OPW] !== exp_op[i]) begin
        n_bad++;
        $display("FAIL %s cell %0d: en=%0b op=%0h expected en=%0b op=%0h",
                 req, i, cell_en_o[i], cell_op_o[i*OPW +: OPW], exp_en[i], exp_op[i]);
      end
    end
  endtask

  task automatic issue(input logic [2:0] m, input logic [OPW-1:0] mo,
                       input logic [OPW-1:0] dop, input logic [OPW-1:0] so,
                       input logic [CELLS-1:0] mk, input logic [ROWS-1:0] rs,
                       input logic [COLS-1:0] cs, input string req);
    @(negedge clk);
    mode_i = m; main_op_i = mo; diag_op_i = dop; sec_op_i = so;
    mask_i = mk; row_sel_i = rs; col_sel_i = cs; valid_i = 1'b1;
    compute_expected();
    @(negedge clk);
    valid_i = 1'b0;
    check_grid(req);
  endtask

  task automatic t_reset();
    for (int i = 0; i < CELLS; i++) begin exp_en[i] = 1'b0; exp_op[i] = '0; end
    check_grid("R1");
  endtask

  task automatic t_broadcast();
    issue(3'b000, 8'h11, 8'h99, 8'h77, '0, '0, '0, "R3");
  endtask

  task automatic t_hold();
    @(negedge clk);
    mode_i = 3'b001; main_op_i = 8'hEE; diag_op_i = 8'hDD; mask_i = '1;
    @(negedge clk);
    @(negedge clk);
    check_grid("R2");
  endtask

  task automatic t_mask();
    issue(3'b000, 8'h5A, 8'h00, 8'h00, 16'h8421, '0, '0, "R4");
    issue(3'b011, 8'h21, 8'h00, 8'h43, 16'hF00F, '0, 4'b0110, "R4");
  endtask

  task automatic t_diag();
    issue(3'b001, 8'h22, 8'h33, 8'h44, 16'h0000, '0, '0, "R5");
    issue(3'b001, 8'h23, 8'h34, 8'h45, 16'h0020, '0, '0, "R5");
  endtask

  task automatic t_row();
    issue(3'b010, 8'h31, 8'h32, 8'h3C, '0, 4'b0101, '0, "R6");
    issue(3'b010, 8'h41, 8'h42, 8'h4C, 16'h0100, 4'b1000, '0, "R6");
  endtask

  task automatic t_col();
    issue(3'b011, 8'h51, 8'h52, 8'h5C, '0, 4'b1111, 4'b1010, "R7");
  endtask

  task automatic t_tri();
    issue(3'b100, 8'h61, 8'h6D, 8'h6C, '0, '0, '0, "R8");
    issue(3'b100, 8'h62, 8'h6E, 8'h6B, 16'h0008, '0, '0, "R8");
  endtask

  task automatic t_trisq();
    issue(3'b101, 8'h71, 8'h7D, 8'h7C, '0, '0, '0, "R9");
  endtask

  task automatic t_reserved();
    issue(3'b110, 8'h81, 8'h8D, 8'h8C, 16'h0001, 4'b1111, 4'b1111, "R10");
    issue(3'b111, 8'h91, 8'h9D, 8'h9C, '0, 4'b1111, 4'b1111, "R10");
  endtask

  logic done;

  initial begin
    done = 1'b0;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; valid_i = 1'b0; mode_i = '0;
    main_op_i = '0; diag_op_i = '0; sec_op_i = '0;
    mask_i = '0; row_sel_i = '0; col_sel_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_broadcast();
    t_hold();
    t_mask();
    t_diag();
    t_row();
    t_col();
    t_tri();
    t_trisq();
    t_reserved();
    t_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule